// File: doc/BRIEF.md
# Buffered Clock-Calendar Core

This block keeps time of day and a 100-year calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A time-base pulse `tick` is counted by a sub-second counter. Once every `TICKS_PER_SEC` ticks, a single update cycle advances every field at once. The update handles carries through to the year, month lengths, leap years and an optional daylight-saving jump.

Two copies of the time are kept. The working copy always advances. The user copy is what the host sees on `usr_time`, and it takes the new working value at each update unless the transfer-inhibit input `uti` is high. Coding is chosen at the ports: `bin_mode` selects binary or BCD, and `h24_mode` selects 24-hour or 12-hour hours. This choice applies both to data the host writes and to the bytes presented on `usr_time`.

Host writes arrive on a valid/ready port. A write is accepted on any clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops only in the single cycle in which an update takes place. The host must then hold `wr_valid`, `wr_addr` and `wr_data` until the next cycle. Status outputs are plain pins: `uip` warns that an update is near, `upd_done` marks a completed update, and `alarm_hit` marks an update that landed on the alarm time.

Top module: `ccal_core`

## Requirements
- R1: The sub-second count advances on every clock edge where `tick` is high. When it wraps after `TICKS_PER_SEC` ticks, all fields advance by one second in a single update. Carries ripple through minute, hour, day, month and year. Year 99 wraps to 00, and day of week runs 1..7 and wraps to 1.
- R2: Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is a multiple of four (00 included) and 28 days otherwise. All other months have 31 days.
- R3: With `bin_mode`=0, every byte written and every byte of `usr_time` is packed BCD (tens in bits 7:4, units in bits 3:0). With `bin_mode`=1 they are plain binary.
- R4: With `h24_mode`=0, the hour byte shows 12, 1..11. Bit 7 is 1 for PM (hours 12:00 to 23:59), and bits 6:0 carry the coded hour. Internal hour 0 shows as 12 AM.
- R5: With `dst_en`=1, the time jumps from 01:59:59 to 03:00:00 on a Sunday (day of week 1) in April with day of month 7 or less. On a Sunday in October with day of month 25 or more, 01:59:59 goes back to 01:00:00 once. The next time 01:59:59 is passed, the time advances normally to 02:00:00.
- R6: While `uti`=1, `usr_time` holds its value across updates and the working copy keeps advancing. After `uti` returns to 0, the next update loads the advanced working time into the user copy.
- R7: `uip` is high during the last `UIP_LEAD` ticks of each second. It is low in the cycle after the update. `upd_done` is high for exactly that one cycle.
- R8: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes and 9 alarm hours. An accepted time write loads both copies at once, so `usr_time` shows the new value in the next cycle. Any accepted write restarts the sub-second count. `wr_ready` is low only in the update cycle.
- R9: `alarm_hit` is high in the cycle after an update whose new seconds, minutes and hours equal the alarm values.
- R10: After reset, the time is year 0, month 1, day 1, day of week 1, 00:00:00. The alarm never matches until it is written, and `uip`, `upd_done` and `alarm_hit` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse, one per sub-second step |
| bin_mode | input | 1 | 1 = binary coding, 0 = BCD |
| h24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enables daylight-saving jumps |
| uti | input | 1 | Freezes the user copy when high |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_addr | input | 4 | Field selector |
| wr_data | input | 8 | Coded field value |
| usr_time | output | 56 | User copy, bytes {yr,mon,dom,dow,hr,min,sec} with seconds in bits 7:0 |
| uip | output | 1 | Update in progress soon |
| upd_done | output | 1 | One-cycle pulse after each update |
| alarm_hit | output | 1 | One-cycle pulse on an alarm match |

## Verification
The assertions rely on two conditions on the host:
- Every written byte is a legal value for its field in the coding selected at that moment.
- `UIP_LEAD` lies between 1 and `TICKS_PER_SEC`-1.

Under those conditions, the seconds byte stays a legal BCD value, and `wr_ready` can only drop while `uip` is up. The bench meets the first condition by encoding every write from binary values through its own encoder, using the mode bits it has just applied. It meets the second by choosing a parameter set of eight ticks per second with a two-tick lead. It also keeps `tick` high throughout, so every update falls on a predictable edge counted from the last write.

// File: rtl/ccal_pkg.sv
package ccal_pkg;
  localparam int FIELDS = 7;

  localparam logic [3:0] ADR_SEC  = 4'd0;
  localparam logic [3:0] ADR_MIN  = 4'd1;
  localparam logic [3:0] ADR_HR   = 4'd2;
  localparam logic [3:0] ADR_DOW  = 4'd3;
  localparam logic [3:0] ADR_DOM  = 4'd4;
  localparam logic [3:0] ADR_MON  = 4'd5;
  localparam logic [3:0] ADR_YR   = 4'd6;
  localparam logic [3:0] ADR_ASEC = 4'd7;
  localparam logic [3:0] ADR_AMIN = 4'd8;
  localparam logic [3:0] ADR_AHR  = 4'd9;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } ccal_time_t;

  localparam ccal_time_t TIME_AT_RESET = '{yr: 8'd0, mon: 8'd1, dom: 8'd1,
                                           dow: 8'd1, hr: 8'd0, min: 8'd0,
                                           sec: 8'd0};

  function automatic logic [7:0] to_bcd(input logic [7:0] b);
    logic [7:0] q;
    logic [7:0] r;
    q = b / 8'd10;
    r = b % 8'd10;
    return {q[3:0], r[3:0]};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] d);
    return ({4'd0, d[7:4]} * 8'd10) + {4'd0, d[3:0]};
  endfunction

  function automatic logic [7:0] dec_val(input logic [7:0] d, input logic bin);
    return bin ? d : from_bcd(d);
  endfunction

  function automatic logic [7:0] dec_hour(input logic [7:0] d, input logic bin,
                                          input logic h24);
    logic [7:0] raw;
    logic [7:0] base;
    if (h24) return dec_val(d, bin);
    raw  = dec_val({1'b0, d[6:0]}, bin);
    base = (raw == 8'd12) ? 8'd0 : raw;
    return d[7] ? base + 8'd12 : base;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                      return (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/ccal_advance.sv
module ccal_advance
  import ccal_pkg::*;
(
  input  ccal_time_t cur,
  input  logic       dst_en,
  input  logic       dst_back,
  output ccal_time_t nxt,
  output logic       dst_back_nxt
);
  logic at_0159;
  logic spring;
  logic fall;

  always_comb begin
    at_0159 = (cur.hr == 8'd1) && (cur.min == 8'd59) && (cur.sec == 8'd59);
    spring  = dst_en && at_0159 && (cur.mon == 8'd4) && (cur.dow == 8'd1) &&
              (cur.dom <= 8'd7);
    fall    = dst_en && at_0159 && (cur.mon == 8'd10) && (cur.dow == 8'd1) &&
              (cur.dom >= 8'd25);
    nxt          = cur;
    dst_back_nxt = dst_back;
    if (spring) begin
      nxt.hr  = 8'd3;
      nxt.min = 8'd0;
      nxt.sec = 8'd0;
    end else if (fall && !dst_back) begin
      nxt.min      = 8'd0;
      nxt.sec      = 8'd0;
      dst_back_nxt = 1'b1;
    end else begin
      if (fall) dst_back_nxt = 1'b0;
      if (cur.sec != 8'd59) nxt.sec = cur.sec + 8'd1;
      else begin
        nxt.sec = 8'd0;
        if (cur.min != 8'd59) nxt.min = cur.min + 8'd1;
        else begin
          nxt.min = 8'd0;
          if (cur.hr != 8'd23) nxt.hr = cur.hr + 8'd1;
          else begin
            nxt.hr  = 8'd0;
            nxt.dow = (cur.dow == 8'd7) ? 8'd1 : cur.dow + 8'd1;
            if (cur.dom != month_len(cur.mon, cur.yr)) nxt.dom = cur.dom + 8'd1;
            else begin
              nxt.dom = 8'd1;
              if (cur.mon != 8'd12) nxt.mon = cur.mon + 8'd1;
              else begin
                nxt.mon = 8'd1;
                nxt.yr  = (cur.yr == 8'd99) ? 8'd0 : cur.yr + 8'd1;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/ccal_codec.sv
module ccal_codec
  import ccal_pkg::*;
(
  input  ccal_time_t        t,
  input  logic              bin_mode,
  input  logic              h24_mode,
  output logic [8*FIELDS-1:0] coded
);
  logic [8*FIELDS-1:0] raw;
  assign raw = t;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    if (i == int'(ADR_HR)) begin : g_hour
      logic [7:0] hr;
      logic [7:0] h12;
      logic [7:0] h12c;
      always_comb begin
        hr   = raw[8*i +: 8];
        h12  = (hr == 8'd0) ? 8'd12 : ((hr > 8'd12) ? hr - 8'd12 : hr);
        h12c = bin_mode ? h12 : to_bcd(h12);
        if (h24_mode) coded[8*i +: 8] = bin_mode ? hr : to_bcd(hr);
        else          coded[8*i +: 8] = {hr >= 8'd12, h12c[6:0]};
      end
    end else begin : g_plain
      always_comb coded[8*i +: 8] = bin_mode ? raw[8*i +: 8] : to_bcd(raw[8*i +: 8]);
    end
  end
endmodule

// File: rtl/ccal_core.sv
module ccal_core
  import ccal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_LEAD      = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bin_mode,
  input  logic        h24_mode,
  input  logic        dst_en,
  input  logic        uti,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [55:0] usr_time,
  output logic        uip,
  output logic        upd_done,
  output logic        alarm_hit
);
  localparam int CW        = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int UIP_START = TICKS_PER_SEC - UIP_LEAD;

  logic [CW-1:0] sub_cnt;
  ccal_time_t    work_t, user_t, nxt_t;
  logic          dst_back, dst_back_nxt;
  logic [7:0]    al_sec, al_min, al_hr;
  logic          last_tick, wr_fire;
  logic [7:0]    wval;

  assign last_tick = tick && (sub_cnt == CW'(TICKS_PER_SEC - 1));
  assign wr_ready  = !last_tick;
  assign wr_fire   = wr_valid && wr_ready;
  assign uip       = (sub_cnt >= CW'(UIP_START));
  assign wval      = ((wr_addr == ADR_HR) || (wr_addr == ADR_AHR)) ?
                     dec_hour(wr_data, bin_mode, h24_mode) : dec_val(wr_data, bin_mode);

  ccal_advance u_adv (
    .cur(work_t), .dst_en(dst_en), .dst_back(dst_back),
    .nxt(nxt_t), .dst_back_nxt(dst_back_nxt)
  );

  ccal_codec u_codec (
    .t(user_t), .bin_mode(bin_mode), .h24_mode(h24_mode), .coded(usr_time)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_cnt   <= '0;
      work_t    <= TIME_AT_RESET;
      user_t    <= TIME_AT_RESET;
      dst_back  <= 1'b0;
      al_sec    <= 8'hFF;
      al_min    <= 8'hFF;
      al_hr     <= 8'hFF;
      upd_done  <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      upd_done  <= 1'b0;
      alarm_hit <= 1'b0;
      if (wr_fire) begin
        sub_cnt <= '0;
        case (wr_addr)
          ADR_SEC:  begin work_t.sec <= wval; user_t.sec <= wval; end
          ADR_MIN:  begin work_t.min <= wval; user_t.min <= wval; end
          ADR_HR:   begin work_t.hr  <= wval; user_t.hr  <= wval; end
          ADR_DOW:  begin work_t.dow <= wval; user_t.dow <= wval; end
          ADR_DOM:  begin work_t.dom <= wval; user_t.dom <= wval; end
          ADR_MON:  begin work_t.mon <= wval; user_t.mon <= wval; end
          ADR_YR:   begin work_t.yr  <= wval; user_t.yr  <= wval; end
          ADR_ASEC: al_sec <= wval;
          ADR_AMIN: al_min <= wval;
          ADR_AHR:  al_hr  <= wval;
          default: ;
        endcase
      end else if (tick) begin
        if (last_tick) begin
          sub_cnt   <= '0;
          work_t    <= nxt_t;
          dst_back  <= dst_back_nxt;
          if (!uti) user_t <= nxt_t;
          upd_done  <= 1'b1;
          alarm_hit <= (nxt_t.sec == al_sec) && (nxt_t.min == al_min) &&
                       (nxt_t.hr == al_hr);
        end else begin
          sub_cnt <= sub_cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ccal_chk.sv
module ccal_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bin_mode,
  input logic        h24_mode,
  input logic        uti,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [55:0] usr_time,
  input logic        uip,
  input logic        upd_done,
  input logic        alarm_hit
);
  // R7: an update is always preceded by the in-progress warning
  p_done_after_uip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(uip));

  // R7: the warning is gone right after the update
  p_uip_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !uip);

  // R8: back-pressure only inside the warning window
  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> uip);

  // R9: alarm pulses only together with an update
  p_alarm_with_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> upd_done);

  // R6: frozen user copy under transfer inhibit
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uti && $past(uti) && !$past(wr_valid && wr_ready) &&
     $stable(bin_mode) && $stable(h24_mode)) |-> $stable(usr_time));

  // R3: seconds byte is legal BCD in BCD mode
  p_bcd_sec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bin_mode |-> (usr_time[3:0] <= 4'd9 && usr_time[7:4] <= 4'd5));
endmodule

bind ccal_core ccal_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bin_mode(bin_mode), .h24_mode(h24_mode),
  .uti(uti), .wr_valid(wr_valid), .wr_ready(wr_ready), .usr_time(usr_time),
  .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
);

// File: tb/sim_ccal_core.sv
module sim_ccal_core;
  localparam int TPS  = 8;
  localparam int LEAD = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic bin_mode = 1'b0, h24_mode = 1'b1, dst_en = 1'b0, uti = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [55:0] usr_time;
  logic uip, upd_done, alarm_hit;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic ended = 1'b0;

  always #5 clk = ~clk;

  ccal_core #(.TICKS_PER_SEC(TPS), .UIP_LEAD(LEAD)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode),
    .h24_mode(h24_mode), .dst_en(dst_en), .uti(uti), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .usr_time(usr_time), .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
  );

  typedef struct packed {
    logic        bin;
    logic        h24;
    logic [7:0]  ns;
    logic [55:0] t;
    logic [55:0] e;
  } vec_t;

  // {yr,mon,dom,dow,hr,min,sec} in binary
  localparam vec_t VEC [9] = '{
    '{1'b0, 1'b1, 8'd1, {8'd99,8'd12,8'd31,8'd7,8'd23,8'd59,8'd59}, {8'd0,8'd1,8'd1,8'd1,8'd0,8'd0,8'd0}},
    '{1'b1, 1'b1, 8'd1, {8'd24,8'd2,8'd28,8'd3,8'd23,8'd59,8'd59},  {8'd24,8'd2,8'd29,8'd4,8'd0,8'd0,8'd0}},
    '{1'b1, 1'b1, 8'd1, {8'd23,8'd2,8'd28,8'd3,8'd23,8'd59,8'd59},  {8'd23,8'd3,8'd1,8'd4,8'd0,8'd0,8'd0}},
    '{1'b0, 1'b1, 8'd1, {8'd21,8'd4,8'd30,8'd5,8'd23,8'd59,8'd59},  {8'd21,8'd5,8'd1,8'd6,8'd0,8'd0,8'd0}},
    '{1'b0, 1'b0, 8'd1, {8'd5,8'd6,8'd15,8'd2,8'd11,8'd59,8'd59},   {8'd5,8'd6,8'd15,8'd2,8'd12,8'd0,8'd0}},
    '{1'b1, 1'b0, 8'd1, {8'd5,8'd6,8'd15,8'd2,8'd23,8'd59,8'd59},   {8'd5,8'd6,8'd16,8'd3,8'd0,8'd0,8'd0}},
    '{1'b0, 1'b1, 8'd3, {8'd30,8'd8,8'd20,8'd4,8'd12,8'd34,8'd56},  {8'd30,8'd8,8'd20,8'd4,8'd12,8'd34,8'd59}},
    '{1'b1, 1'b1, 8'd2, {8'd30,8'd8,8'd20,8'd4,8'd0,8'd0,8'd58},    {8'd30,8'd8,8'd20,8'd4,8'd0,8'd1,8'd0}},
    '{1'b0, 1'b1, 8'd1, {8'd24,8'd2,8'd29,8'd5,8'd23,8'd59,8'd59},  {8'd24,8'd3,8'd1,8'd6,8'd0,8'd0,8'd0}}
  };

  function automatic logic [7:0] benc(input logic [7:0] v, input logic bin);
    return bin ? v : {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] benc_hr(input logic [7:0] h, input logic bin, input logic h24);
    logic [7:0] h12;
    logic [7:0] c;
    if (h24) return benc(h, bin);
    h12 = (h % 8'd12 == 8'd0) ? 8'd12 : h % 8'd12;
    c = benc(h12, bin);
    return {h >= 8'd12, c[6:0]};
  endfunction

  function automatic logic [55:0] benc_t(input logic [55:0] t, input logic bin, input logic h24);
    logic [55:0] r;
    for (int i = 0; i < 7; i++)
      r[8*i +: 8] = (i == 2) ? benc_hr(t[8*i +: 8], bin, h24) : benc(t[8*i +: 8], bin);
    return r;
  endfunction

  task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ends on the negedge following the accepted write
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    forever begin
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      if (wr_ready) break;
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr_time(input logic [55:0] t);
    for (int i = 0; i < 7; i++)
      wr(4'(i), (i == 2) ? benc_hr(t[8*i +: 8], bin_mode, h24_mode) : benc(t[8*i +: 8], bin_mode));
  endtask

  task automatic secs(input int n);
    repeat (n * TPS) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 time", usr_time, 56'h00_01_01_01_00_00_00);
    chk("R10 flags", {53'd0, uip, upd_done, alarm_hit}, 56'd0);

    // table of vectors: R1 R2 R3 R4
    for (int v = 0; v < 9; v++) begin
      @(negedge clk);
      bin_mode = VEC[v].bin; h24_mode = VEC[v].h24;
      wr_time(VEC[v].t);
      secs(int'(VEC[v].ns));
      chk($sformatf("vector %0d (R1 R2 R3 R4)", v), usr_time,
          benc_t(VEC[v].e, VEC[v].bin, VEC[v].h24));
    end

    // R3: same value in both codings
    bin_mode = 1'b1; h24_mode = 1'b1;
    wr(4'd0, 8'd59);
    chk("R3 binary sec", {48'd0, usr_time[7:0]}, 56'h3B);
    bin_mode = 1'b0;
    #1 chk("R3 bcd sec", {48'd0, usr_time[7:0]}, 56'h59);

    // R7 and R8: window timing after a write (now at sub-count 0)
    bin_mode = 1'b1;
    wr(4'd0, 8'd10);
    repeat (5) @(negedge clk);
    chk("R7 uip low at 5", {55'd0, uip}, 56'd0);
    @(negedge clk);
    chk("R7 uip high at 6", {55'd0, uip}, 56'd1);
    @(negedge clk);
    chk("R8 ready low in update cycle", {54'd0, uip, wr_ready}, 56'd2);
    @(negedge clk);
    chk("R7 after update", {53'd0, uip, upd_done, wr_ready}, 56'd3);
    chk("R1 sec advanced", {48'd0, usr_time[7:0]}, 56'd11);
    @(negedge clk);
    chk("R7 done one cycle", {55'd0, upd_done}, 56'd0);

    // R8: a write restarts the sub-second count
    wr(4'd0, 8'd20);
    repeat (4) @(negedge clk);
    wr(4'd0, 8'd30);
    repeat (7) @(negedge clk);
    chk("R8 restart no advance", {48'd0, usr_time[7:0]}, 56'd30);
    @(negedge clk);
    chk("R8 restart advance", {48'd0, usr_time[7:0]}, 56'd31);

    // R6: transfer inhibit
    wr(4'd0, 8'd10);
    uti = 1'b1;
    secs(3);
    chk("R6 frozen", {48'd0, usr_time[7:0]}, 56'd10);
    uti = 1'b0;
    secs(1);
    chk("R6 catch up", {48'd0, usr_time[7:0]}, 56'd14);
    uti = 1'b1;
    wr(4'd0, 8'd40);
    chk("R8 write under inhibit", {48'd0, usr_time[7:0]}, 56'd40);
    uti = 1'b0;

    // R9: alarm
    wr(4'd7, 8'd5); wr(4'd8, 8'd0); wr(4'd9, 8'd0);
    wr_time({8'd22, 8'd3, 8'd9, 8'd2, 8'd0, 8'd0, 8'd3});
    secs(1);
    chk("R9 no hit at 4", {55'd0, alarm_hit}, 56'd0);
    secs(1);
    chk("R9 hit at 5", {54'd0, alarm_hit, upd_done}, 56'd3);
    @(negedge clk);
    chk("R9 pulse ends", {55'd0, alarm_hit}, 56'd0);

    // R5: daylight saving
    dst_en = 1'b1;
    wr_time({8'd21, 8'd4, 8'd3, 8'd1, 8'd1, 8'd59, 8'd59});
    secs(1);
    chk("R5 spring", usr_time, {8'd21, 8'd4, 8'd3, 8'd1, 8'd3, 8'd0, 8'd0});
    wr_time({8'd21, 8'd10, 8'd30, 8'd1, 8'd1, 8'd59, 8'd59});
    secs(1);
    chk("R5 fall back", usr_time, {8'd21, 8'd10, 8'd30, 8'd1, 8'd1, 8'd0, 8'd0});
    wr_time({8'd21, 8'd10, 8'd30, 8'd1, 8'd1, 8'd59, 8'd59});
    secs(1);
    chk("R5 second pass", usr_time, {8'd21, 8'd10, 8'd30, 8'd1, 8'd2, 8'd0, 8'd0});
    dst_en = 1'b0;

    finish_run();
  end
endmodule